// File: doc/BRIEF.md
# Fast Register Memory Unit

This block is a sixteen-word store of 36-bit words that sits on a processor memory bus and answers the cycles of exactly one processor port, fixed by a parameter. The processor raises a cycle request together with its port number, read and write request flags and four address lines. When the unit is idle and the port number is its own, it takes the cycle. It latches the address and returns an address acknowledge strobe. If a read is requested, it also returns the stored word with a read-restart strobe in the same cycle.

A write works in two steps. Taking the cycle zeroes the addressed word. After that, any nonzero word on the data lines is ORed into it for as long as the write is pending and no read is requested. Each merge raises a take strobe, which tells the bus to clear its data lines. A read-only cycle closes as soon as it is taken. A cycle that writes stays open until a rising edge on the write-restart line.

A request from any other port raises a decline flag at once. A router uses this flag to pass the cycle on to core memory.

Top module: `fastreg_unit`

## Requirements
- R1: After reset the unit is idle, every strobe output is low, the read data output is zero and every stored word reads as zero.
- R2: A cycle request whose port number differs from the parameter OWN_PORT raises `decline` in the same cycle. It causes no acknowledge, no read data and no change to any stored word.
- R3: An idle unit that sees a cycle request from its own port pulses `addr_ack` for one cycle after the accepting clock edge. The address used is the one on `addr_lines`, which carries bus bits 7 down to 4.
- R4: An accepted cycle with the read flag set pulses `rd_restart` together with `addr_ack`, and `rd_data` shows the word stored at the address before the edge.
- R5: A cycle whose read flag is set and whose write flag is clear closes at once, with no write-restart needed. An own-port request in the very next cycle is accepted.
- R6: An accepted cycle with the write flag set zeroes the addressed word. If no nonzero data follows, the word reads back as zero.
- R7: While a write is pending and the read flag is low, nonzero `data_in` is ORed into the latched location and `data_take` pulses one cycle later. All-zero data produces no take and no change. A write-only request carrying data merges in its accepting cycle.
- R8: A rising edge on `wr_restart` closes the open cycle, including in the same cycle as a merge or an accept. A level that stays high closes nothing further.
- R9: While a cycle is open, own-port requests receive no acknowledge and no read data.
- R10: A cycle with both flags set returns the old word and zeroes the location. No merge takes place until the read flag falls.
- R11: Successive merges within one write cycle accumulate by bitwise OR.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cyc_req | input | 1 | Cycle request level from the bus |
| req_port | input | PORT_W | Number of the requesting processor port |
| rd_req | input | 1 | Read requested |
| wr_req | input | 1 | Write requested |
| addr_lines | input | ADDR_W | Word address, bus bits 7..4 |
| wr_restart | input | 1 | Write-restart line; its rising edge closes a cycle |
| data_in | input | WORD_W | Data lines from the processor |
| decline | output | 1 | Request belongs to another port; route elsewhere |
| addr_ack | output | 1 | Address acknowledge strobe |
| rd_restart | output | 1 | Read-restart strobe, read word valid |
| rd_data | output | WORD_W | Word returned by the last read |
| data_take | output | 1 | Data merged; bus should clear its data lines |

## Verification
Two pairs of events can land on the same clock edge. An accept can coincide with a merge, and a merge can coincide with the write-restart edge. The bench raises a write-only request with nonzero data and a rising restart in one cycle. It then expects an acknowledge and a take in the following cycle, an idle unit afterwards, and the merged word on a later read. A behavioural model steps through the same accept, clear, merge and close order on every edge and compares all outputs against it.

// File: rtl/fastreg_pkg.sv
package fastreg_pkg;

    localparam int FR_WORD_W = 36;
    localparam int FR_DEPTH  = 16;
    localparam int FR_PORT_W = 2;

    typedef struct packed {
        logic cyc;
        logic rd;
        logic wr;
    } fr_req_t;

endpackage

// File: rtl/fastreg_edge.sv
module fastreg_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic level_in,
    output logic rise
);
    logic prev_d, prev_q;

    always_comb begin
        prev_d = level_in;
        rise   = level_in & ~prev_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= prev_d;
    end
endmodule

// File: rtl/fastreg_store.sv
module fastreg_store #(
    parameter int WORD_W = 36,
    parameter int DEPTH  = 16,
    localparam int ADDR_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr_en,
    input  logic [ADDR_W-1:0] clr_addr,
    input  logic              or_en,
    input  logic [ADDR_W-1:0] or_addr,
    input  logic [WORD_W-1:0] or_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [WORD_W-1:0] rd_word
);
    logic [WORD_W-1:0] mem_q [DEPTH];
    logic [WORD_W-1:0] mem_d [DEPTH];

    for (genvar i = 0; i < DEPTH; i++) begin : g_word
        localparam logic [ADDR_W-1:0] IDX = ADDR_W'(i);
        logic [WORD_W-1:0] base;
        // clear happens before the merge when both target this word
        always_comb begin
            base     = (clr_en && clr_addr == IDX) ? '0 : mem_q[i];
            mem_d[i] = base | ((or_en && or_addr == IDX) ? or_data : '0);
        end
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) mem_q[i] <= '0;
            else        mem_q[i] <= mem_d[i];
        end
    end

    assign rd_word = mem_q[rd_addr];
endmodule

// File: rtl/fastreg_ctrl.sv
module fastreg_ctrl
    import fastreg_pkg::*;
#(
    parameter int WORD_W   = 36,
    parameter int DEPTH    = 16,
    parameter int PORT_W   = 2,
    parameter int OWN_PORT = 1,
    localparam int ADDR_W  = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  fr_req_t           req,
    input  logic [PORT_W-1:0] req_port,
    input  logic [ADDR_W-1:0] addr_lines,
    input  logic [WORD_W-1:0] data_in,
    input  logic              restart_rise,
    input  logic [WORD_W-1:0] rd_word,
    output logic [ADDR_W-1:0] rd_addr,
    output logic              clr_en,
    output logic [ADDR_W-1:0] clr_addr,
    output logic              or_en,
    output logic [ADDR_W-1:0] or_addr,
    output logic [WORD_W-1:0] or_data,
    output logic              decline,
    output logic              addr_ack,
    output logic              rd_restart,
    output logic [WORD_W-1:0] rd_data,
    output logic              data_take
);
    localparam logic [PORT_W-1:0] MY_PORT = PORT_W'(OWN_PORT);

    typedef struct packed {
        logic              active;
        logic              wpend;
        logic [ADDR_W-1:0] addr;
        logic              ack;
        logic              rrs;
        logic              take;
        logic [WORD_W-1:0] rdata;
    } st_t;

    st_t st_d, st_q;

    logic              own_req;
    logic              accept;
    logic              act_now;
    logic              wp_now;
    logic [ADDR_W-1:0] cur_addr;
    logic              merge;

    always_comb begin
        st_d      = st_q;
        st_d.ack  = 1'b0;
        st_d.rrs  = 1'b0;
        st_d.take = 1'b0;

        own_req  = req.cyc && (req_port == MY_PORT);
        decline  = req.cyc && (req_port != MY_PORT);
        accept   = own_req && !st_q.active;

        act_now  = st_q.active;
        wp_now   = st_q.wpend;
        cur_addr = st_q.addr;

        rd_addr  = addr_lines;
        clr_addr = addr_lines;
        clr_en   = 1'b0;

        // step 1: take the cycle, serve a read, open a write
        if (accept) begin
            act_now  = 1'b1;
            cur_addr = addr_lines;
            st_d.ack = 1'b1;
            if (req.rd) begin
                st_d.rdata = rd_word;
                st_d.rrs   = 1'b1;
                if (!req.wr) act_now = 1'b0;
            end
            if (req.wr) begin
                clr_en = 1'b1;
                wp_now = 1'b1;
            end
        end

        // step 2: merge nonzero data while writing and not reading
        merge     = act_now && wp_now && !req.rd && (data_in != '0);
        or_en     = merge;
        or_addr   = cur_addr;
        or_data   = data_in;
        st_d.take = merge;

        // step 3: restart edge closes whatever is open
        if (restart_rise) begin
            act_now = 1'b0;
            wp_now  = 1'b0;
        end

        st_d.active = act_now;
        st_d.wpend  = wp_now;
        st_d.addr   = cur_addr;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign addr_ack   = st_q.ack;
    assign rd_restart = st_q.rrs;
    assign data_take  = st_q.take;
    assign rd_data    = st_q.rdata;
endmodule

// File: rtl/fastreg_unit.sv
module fastreg_unit
    import fastreg_pkg::*;
#(
    parameter int WORD_W   = FR_WORD_W,
    parameter int DEPTH    = FR_DEPTH,
    parameter int PORT_W   = FR_PORT_W,
    parameter int OWN_PORT = 1,
    localparam int ADDR_W  = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cyc_req,
    input  logic [PORT_W-1:0] req_port,
    input  logic              rd_req,
    input  logic              wr_req,
    input  logic [ADDR_W-1:0] addr_lines,
    input  logic              wr_restart,
    input  logic [WORD_W-1:0] data_in,
    output logic              decline,
    output logic              addr_ack,
    output logic              rd_restart,
    output logic [WORD_W-1:0] rd_data,
    output logic              data_take
);
    fr_req_t           req;
    logic              restart_rise;
    logic [WORD_W-1:0] rd_word;
    logic [ADDR_W-1:0] rd_addr;
    logic              clr_en;
    logic [ADDR_W-1:0] clr_addr;
    logic              or_en;
    logic [ADDR_W-1:0] or_addr;
    logic [WORD_W-1:0] or_data;

    assign req = '{cyc: cyc_req, rd: rd_req, wr: wr_req};

    fastreg_edge u_edge (
        .clk      (clk),
        .rst_n    (rst_n),
        .level_in (wr_restart),
        .rise     (restart_rise)
    );

    fastreg_store #(.WORD_W(WORD_W), .DEPTH(DEPTH)) u_store (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr_en   (clr_en),
        .clr_addr (clr_addr),
        .or_en    (or_en),
        .or_addr  (or_addr),
        .or_data  (or_data),
        .rd_addr  (rd_addr),
        .rd_word  (rd_word)
    );

    fastreg_ctrl #(
        .WORD_W(WORD_W), .DEPTH(DEPTH), .PORT_W(PORT_W), .OWN_PORT(OWN_PORT)
    ) u_ctrl (
        .clk          (clk),
        .rst_n        (rst_n),
        .req          (req),
        .req_port     (req_port),
        .addr_lines   (addr_lines),
        .data_in      (data_in),
        .restart_rise (restart_rise),
        .rd_word      (rd_word),
        .rd_addr      (rd_addr),
        .clr_en       (clr_en),
        .clr_addr     (clr_addr),
        .or_en        (or_en),
        .or_addr      (or_addr),
        .or_data      (or_data),
        .decline      (decline),
        .addr_ack     (addr_ack),
        .rd_restart   (rd_restart),
        .rd_data      (rd_data),
        .data_take    (data_take)
    );
endmodule

// File: rtl/fastreg_chk.sv
module fastreg_chk #(
    parameter int WORD_W = 36,
    parameter int PORT_W = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cyc_req,
    input logic [PORT_W-1:0] req_port,
    input logic              rd_req,
    input logic [WORD_W-1:0] data_in,
    input logic              decline,
    input logic              addr_ack,
    input logic              rd_restart,
    input logic              data_take
);
    assert_decline_noack_R2: assert property (@(posedge clk) disable iff (!rst_n)
        decline |=> !addr_ack);

    assert_ack_after_req_R3: assert property (@(posedge clk) disable iff (!rst_n)
        addr_ack |-> $past(cyc_req));

    assert_rrs_with_ack_R4: assert property (@(posedge clk) disable iff (!rst_n)
        rd_restart |-> addr_ack);

    assert_take_nonzero_R7: assert property (@(posedge clk) disable iff (!rst_n)
        data_take |-> $past(data_in != '0));

    assert_take_no_read_R10: assert property (@(posedge clk) disable iff (!rst_n)
        data_take |-> !$past(rd_req));
endmodule

bind fastreg_unit fastreg_chk #(.WORD_W(WORD_W), .PORT_W(PORT_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cyc_req    (cyc_req),
    .req_port   (req_port),
    .rd_req     (rd_req),
    .data_in    (data_in),
    .decline    (decline),
    .addr_ack   (addr_ack),
    .rd_restart (rd_restart),
    .data_take  (data_take)
);

// File: tb/test_fastreg_unit.sv
module test_fastreg_unit;
    localparam int W  = 36;
    localparam int PW = 2;
    localparam int AW = 4;
    localparam int OWN = 1;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cyc_req = 1'b0;
    logic [PW-1:0] req_port = '0;
    logic          rd_req = 1'b0;
    logic          wr_req = 1'b0;
    logic [AW-1:0] addr_lines = '0;
    logic          wr_restart = 1'b0;
    logic [W-1:0]  data_in = '0;
    logic          decline, addr_ack, rd_restart, data_take;
    logic [W-1:0]  rd_data;

    int  vectors = 0;
    int  fails = 0;
    bit  started = 0;
    bit  done = 0;

    always #5 clk = ~clk;

    fastreg_unit #(.WORD_W(W), .DEPTH(16), .PORT_W(PW), .OWN_PORT(OWN)) i_fastreg_unit (
        .clk(clk), .rst_n(rst_n), .cyc_req(cyc_req), .req_port(req_port),
        .rd_req(rd_req), .wr_req(wr_req), .addr_lines(addr_lines),
        .wr_restart(wr_restart), .data_in(data_in), .decline(decline),
        .addr_ack(addr_ack), .rd_restart(rd_restart), .rd_data(rd_data),
        .data_take(data_take)
    );

    // behavioural reference
    logic [W-1:0] mdl_mem [16];
    bit           mdl_open = 0, mdl_wp = 0, mdl_prev = 0;
    int           mdl_addr = 0;
    bit           e_ack = 0, e_rrs = 0, e_take = 0;
    logic [W-1:0] e_rdata = '0;

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int k = 0; k < 16; k++) mdl_mem[k] = '0;
            mdl_open = 0; mdl_wp = 0; mdl_prev = 0;
            e_ack = 0; e_rrs = 0; e_take = 0; e_rdata = '0;
        end else begin
            bit edge_seen;
            edge_seen = wr_restart && !mdl_prev;
            mdl_prev  = wr_restart;
            e_ack = 0; e_rrs = 0; e_take = 0;
            if (cyc_req && int'(req_port) == OWN && !mdl_open) begin
                mdl_open = 1;
                mdl_addr = int'(addr_lines);
                e_ack = 1;
                if (rd_req) begin
                    e_rdata = mdl_mem[mdl_addr];
                    e_rrs = 1;
                    if (!wr_req) mdl_open = 0;
                end
                if (wr_req) begin
                    mdl_mem[mdl_addr] = '0;
                    mdl_wp = 1;
                end
            end
            if (mdl_open && mdl_wp && !rd_req && data_in != '0) begin
                mdl_mem[mdl_addr] = mdl_mem[mdl_addr] | data_in;
                e_take = 1;
            end
            if (edge_seen) begin
                mdl_open = 0;
                mdl_wp = 0;
            end
        end
    end

    task automatic chk(input logic [W-1:0] act, input logic [W-1:0] exp, input string tag);
        vectors++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (started && rst_n) begin
            chk(W'(addr_ack),   W'(e_ack),  "R3 addr_ack vs model");
            chk(W'(rd_restart), W'(e_rrs),  "R4 rd_restart vs model");
            chk(rd_data,        e_rdata,    "R4 rd_data vs model");
            chk(W'(data_take),  W'(e_take), "R7 data_take vs model");
        end
    end

    task automatic drive(input bit c, input int p, input bit r, input bit w,
                         input int a, input logic [W-1:0] d, input bit rs);
        @(posedge clk);
        #2;
        cyc_req = c; req_port = PW'(p); rd_req = r; wr_req = w;
        addr_lines = AW'(a); data_in = d; wr_restart = rs;
        #1;
        chk(W'(decline), W'(c && p != OWN), "R2 decline");
    endtask

    task automatic idle();
        drive(0, OWN, 0, 0, 0, '0, 0);
    endtask

    task automatic rd_check(input int a, input logic [W-1:0] exp, input string tag);
        drive(1, OWN, 1, 0, a, '0, 0);
        idle();
        chk(W'(addr_ack), W'(1), tag);
        chk(rd_data, exp, tag);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        fails++;
        $display("FAIL all: watchdog expired, actual hung expected finished");
        finish_run();
    end

    localparam logic [W-1:0] A = 36'hA_5A5A_0F0F;
    localparam logic [W-1:0] B = 36'h0_0F00_F0F1;
    localparam logic [W-1:0] C = 36'h3_1234_5678;
    localparam logic [W-1:0] D = 36'hC_0000_0003;
    localparam logic [W-1:0] E = 36'h0_DEAD_BEEF;
    localparam logic [W-1:0] F = 36'h8_0000_0001;
    localparam logic [W-1:0] G = 36'h5_5555_5555;
    localparam logic [W-1:0] H = 36'hF_FFFF_FFFF;

    initial begin
        repeat (3) @(posedge clk);
        #2 rst_n = 1'b1;
        started = 1;
        #1;
        chk(W'({addr_ack, rd_restart, data_take}), '0, "R1 strobes after reset");
        chk(rd_data, '0, "R1 rd_data after reset");

        // R1 / R3: read an untouched word
        rd_check(5, '0, "R1 word zero after reset");
        chk(W'(rd_restart), W'(1), "R3 read accepted from own port");

        // R7 / R11: write-only with data merges in its accepting cycle, then accumulates
        drive(1, OWN, 0, 1, 3, A, 0);
        drive(0, OWN, 0, 1, 3, B, 0);
        chk(W'(data_take), W'(1), "R7 merge on accept");
        drive(0, OWN, 0, 1, 3, '0, 1);
        chk(W'(data_take), W'(1), "R11 second merge");
        idle();
        chk(W'(data_take), W'(0), "R7 zero data no take");
        rd_check(3, A | B, "R11 accumulated word");

        // R6: write with no data leaves zero
        drive(1, OWN, 0, 1, 3, '0, 0);
        drive(0, OWN, 0, 1, 3, '0, 0);
        chk(W'(data_take), W'(0), "R6 no take without data");
        drive(0, OWN, 0, 0, 3, '0, 1);
        idle();
        rd_check(3, '0, "R6 cleared word");

        // R8: accept, merge and restart edge in one cycle
        drive(1, OWN, 0, 1, 3, C, 1);
        idle();
        chk(W'(data_take), W'(1), "R8 merge with restart edge");
        rd_check(3, C, "R8 cycle closed, next accepted");

        // R10: read+write cycle
        drive(1, OWN, 1, 1, 3, D, 0);
        drive(0, OWN, 1, 1, 3, D, 0);
        chk(W'(rd_restart), W'(1), "R10 read restart");
        chk(rd_data, C, "R10 old word returned");
        chk(W'(data_take), W'(0), "R10 no merge while reading");
        drive(0, OWN, 0, 1, 3, D, 0);
        chk(W'(data_take), W'(0), "R10 still reading previous cycle");
        drive(0, OWN, 0, 1, 3, '0, 1);
        chk(W'(data_take), W'(1), "R10 merge after read falls");
        idle();
        rd_check(3, D, "R10 final word");

        // R9: own request while a write is open
        drive(1, OWN, 0, 1, 7, '0, 0);
        drive(1, OWN, 1, 0, 9, '0, 0);
        drive(0, OWN, 0, 0, 7, '0, 0);
        chk(W'(addr_ack), W'(0), "R9 busy no ack");
        chk(W'(rd_restart), W'(0), "R9 busy no read");
        drive(0, OWN, 0, 0, 7, '0, 1);
        idle();
        rd_check(9, '0, "R9 accepted after close");

        // R5: back-to-back read-only cycles
        drive(1, OWN, 0, 1, 2, E, 1);
        idle();
        drive(1, OWN, 0, 1, 4, F, 1);
        idle();
        drive(1, OWN, 1, 0, 2, '0, 0);
        drive(1, OWN, 1, 0, 4, '0, 0);
        chk(rd_data, E, "R5 first read");
        idle();
        chk(W'(addr_ack), W'(1), "R5 second read accepted at once");
        chk(rd_data, F, "R5 second read data");

        // R8: restart held high does not close a new cycle
        drive(0, OWN, 0, 0, 0, '0, 1);
        drive(1, OWN, 0, 1, 6, G, 1);
        drive(1, OWN, 1, 0, 6, '0, 1);
        drive(0, OWN, 0, 0, 6, '0, 1);
        chk(W'(addr_ack), W'(0), "R8 level high keeps cycle open");
        drive(0, OWN, 0, 0, 6, '0, 0);
        drive(0, OWN, 0, 0, 6, '0, 1);
        idle();
        rd_check(6, G, "R8 closed by later edge");

        // R2: foreign port requests
        drive(1, 2, 1, 0, 5, '0, 0);
        idle();
        chk(W'(addr_ack), W'(0), "R2 foreign read ignored");
        drive(1, 0, 0, 1, 6, H, 0);
        drive(0, 0, 0, 1, 6, H, 0);
        chk(W'(addr_ack), W'(0), "R2 foreign write ignored");
        drive(0, 0, 0, 0, 6, '0, 1);
        idle();
        rd_check(6, G, "R2 word unchanged by foreign write");

        idle();
        idle();
        finish_run();
    end
endmodule